// File: doc/BRIEF.md
# Multi-Function Port Mux

This block assigns a function to each of the five general-purpose pins of one line channel. Three pins sit on the receive side and two on the transmit side. Each pin has its own 4-bit function code held in a small register file. The code either leaves the pin as an input, drives a fixed level, or routes one of the channel's internal status signals to the pin. On a receive-side pin, one code routes the recovered receive clock instead. The pad cell outside the block takes the per-pin output data and output enable, and it returns the level it actually sees on the pin.

The third receive-side pin comes out of reset selecting the recovered clock. That clock only reaches the pin once a separate clock-output enable bit is set. Until then the pin stays undriven and the external pull-up holds it high. Software can read the real level of all five pins at one status address. It gets that level through a two-flop synchronizer. Together with the fixed-level codes, this lets an unused pin work as a plain general-purpose input or output.

Function changes are decoded from the value being written, not from the stored copy. The output enable therefore comes straight from a flop and moves on the same edge that stores the new code.

Top module: `mfp_port_mux`

## Requirements
- R1: After reset every pin has its output enable at 0. The stored codes are 0 for every pin except the third receive-side pin, whose code is 15. The clock-output enable bit is 0.
- R2: Code 0 makes a pin an input: its output enable is 0.
- R3: Code 1 drives the pin low and code 2 drives it high, each with the output enable at 1.
- R4: Code 3+i, for i from 0 to NUM_CAND-1 (codes 3..10 at the default of 8), drives the pin with internal candidate signal cand_in[i], with the output enable at 1.
- R5: Code 15 on a receive-side pin drives rx_clk_in on the pin. The output enable equals the clock-output enable bit (address 3, bit 0), so the pin is undriven while that bit is 0.
- R6: Codes 11..14 on any pin, and code 15 on a transmit-side pin, are undefined and act as input mode with the output enable at 0.
- R7: A register write changes the stored code, the output enable and the output data on the clock edge that samples the write, and not earlier.
- R8: Address 4 reads pin_in in bits 4:0, ordered rx A, rx B, rx C, tx A, tx B from bit 0, with bits 7:5 at 0. A pin level change is first visible after the second rising edge that follows it.
- R9: Register map. Address 0 holds rx A in bits 3:0 and rx B in bits 7:4. Address 1 holds rx C in bits 3:0 and tx A in bits 7:4. Address 2 holds tx B in bits 3:0, and bits 7:4 read 0. Address 3 holds the clock-output enable in bit 0, and bits 7:1 read 0. Writes to addresses 4..7 change nothing, and addresses 5..7 read 0.
- R10: Whenever a pin's output enable is 0, its output data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from reg_addr |
| cand_in | input | NUM_CAND | Internal status signals that can be routed to pins |
| rx_clk_in | input | 1 | Recovered receive clock |
| pin_in | input | 5 | Levels seen at the five pins |
| pin_out | output | 5 | Output data for the five pins |
| pin_oe | output | 5 | Output enable for the five pins |

## Verification
Two things can happen in the same cycle: a write that changes a pin's drive, and a change of the level that pin reports back. The bench provokes this by writing the clock-output enable and changing pin_in at the same falling edge. It expects the enable to move after one rising edge, while the readback still shows the old level. The readback must then show the new level only after the second rising edge. A second overlap is a candidate signal toggling while a code write lands. Here the output must follow the newly selected source from the same edge onward.

// File: rtl/mfp_pkg.sv
// Package: shared constants, decoded drive kinds and the function-code decoder
// for the multi-function port mux. Assumes NUM_CAND is at most 12, so the
// candidate code range never reaches the clock code.
package mfp_pkg;

    localparam int NUM_RX    = 3;
    localparam int NUM_TX    = 2;
    localparam int NUM_PINS  = NUM_RX + NUM_TX;
    localparam int CODE_W    = 4;
    localparam int REG_AW    = 3;
    localparam int REG_DW    = 8;
    localparam int CLK_PIN   = 2;

    localparam logic [CODE_W-1:0] CODE_INPUT = 4'd0;
    localparam logic [CODE_W-1:0] CODE_LOW   = 4'd1;
    localparam logic [CODE_W-1:0] CODE_HIGH  = 4'd2;
    localparam logic [CODE_W-1:0] CODE_SIG0  = 4'd3;
    localparam logic [CODE_W-1:0] CODE_CLK   = 4'd15;

    localparam logic [REG_AW-1:0] ADDR_CTRL   = 3'd3;
    localparam logic [REG_AW-1:0] ADDR_STATUS = 3'd4;

    typedef enum logic [1:0] {
        DRV_NONE   = 2'd0,
        DRV_STATIC = 2'd1,
        DRV_SIG    = 2'd2,
        DRV_CLK    = 2'd3
    } drive_kind_t;

    typedef struct packed {
        drive_kind_t kind;
        logic        level;
        logic [3:0]  sig_idx;
    } pin_drive_t;

    // Reset code of pin i: the clock pin starts on the clock code.
    function automatic logic [CODE_W-1:0] reset_code(input int pin);
        return (pin == CLK_PIN) ? CODE_CLK : CODE_INPUT;
    endfunction

    // Decode one function code into a drive description.
    function automatic pin_drive_t decode_code(input logic [CODE_W-1:0] code,
                                               input bit is_rx,
                                               input int num_cand);
        pin_drive_t d;
        d.kind    = DRV_NONE;
        d.level   = 1'b0;
        d.sig_idx = 4'd0;
        if (code == CODE_LOW) begin
            d.kind = DRV_STATIC;
        end else if (code == CODE_HIGH) begin
            d.kind  = DRV_STATIC;
            d.level = 1'b1;
        end else if (code == CODE_CLK) begin
            if (is_rx) d.kind = DRV_CLK;
        end else if (code >= CODE_SIG0 &&
                     int'(code) < int'(CODE_SIG0) + num_cand) begin
            d.kind    = DRV_SIG;
            d.sig_idx = code - CODE_SIG0;
        end
        return d;
    endfunction

endpackage

// File: rtl/mfp_cfg_regs.sv
// Register file: stores the per-pin function codes and the clock-output
// enable, and muxes read data. It also exposes the next-state values so that
// the output enables can be registered on the write edge. Assumes a single
// write port, where codes pack two per byte address.
module mfp_cfg_regs
    import mfp_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              reg_we,
    input  logic [REG_AW-1:0]                 reg_addr,
    input  logic [REG_DW-1:0]                 reg_wdata,
    input  logic [NUM_PINS-1:0]               status_in,
    output logic [REG_DW-1:0]                 reg_rdata,
    output logic [NUM_PINS-1:0][CODE_W-1:0]   code_q,
    output logic [NUM_PINS-1:0][CODE_W-1:0]   code_d,
    output logic                              clk_en_q,
    output logic                              clk_en_d
);

    localparam int CODES_PER_ADDR = REG_DW / CODE_W;
    localparam int NUM_CODE_ADDR  = (NUM_PINS + CODES_PER_ADDR - 1) / CODES_PER_ADDR;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_code
            localparam int ADDR = gi / CODES_PER_ADDR;
            localparam int LANE = gi % CODES_PER_ADDR;

            // Next code: write data lane when this pin's address is written.
            always_comb begin
                code_d[gi] = code_q[gi];
                if (reg_we && int'(reg_addr) == ADDR)
                    code_d[gi] = reg_wdata[LANE*CODE_W +: CODE_W];
            end

            // Code storage with its per-pin reset value.
            always_ff @(posedge clk) begin
                if (!rst_n) code_q[gi] <= reset_code(gi);
                else        code_q[gi] <= code_d[gi];
            end
        end
    endgenerate

    // Next clock-output enable.
    always_comb begin
        clk_en_d = clk_en_q;
        if (reg_we && reg_addr == ADDR_CTRL) clk_en_d = reg_wdata[0];
    end

    // Clock-output enable storage, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) clk_en_q <= 1'b0;
        else        clk_en_q <= clk_en_d;
    end

    // Read mux: code bytes, control bit, synchronized pin status.
    always_comb begin
        reg_rdata = '0;
        if (int'(reg_addr) < NUM_CODE_ADDR) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (p / CODES_PER_ADDR == int'(reg_addr))
                    reg_rdata[(p % CODES_PER_ADDR)*CODE_W +: CODE_W] = code_q[p];
            end
        end else if (reg_addr == ADDR_CTRL) begin
            reg_rdata[0] = clk_en_q;
        end else if (reg_addr == ADDR_STATUS) begin
            reg_rdata[NUM_PINS-1:0] = status_in;
        end
    end

endmodule

// File: rtl/mfp_pin_slice.sv
// One pin's function decoder and output stage. The output enable is a flop
// loaded from the decoded next code, so it never glitches and moves on the
// write edge. Data is selected from the stored code and is forced to 0
// while the enable is low. Assumes the candidates are synchronous to clk,
// apart from the recovered clock, which passes through as data.
module mfp_pin_slice
    import mfp_pkg::*;
#(
    parameter bit IS_RX    = 1'b1,
    parameter int NUM_CAND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CODE_W-1:0]   code_q,
    input  logic [CODE_W-1:0]   code_d,
    input  logic                clk_en_d,
    input  logic [NUM_CAND-1:0] cand_in,
    input  logic                rx_clk_in,
    output logic                pad_out,
    output logic                pad_oe
);

    pin_drive_t drv_now;
    pin_drive_t drv_next;
    logic       oe_next;
    logic       oe_q;
    logic       data_sel;

    // Decode the stored and the next function codes.
    always_comb begin
        drv_now  = decode_code(code_q, IS_RX, NUM_CAND);
        drv_next = decode_code(code_d, IS_RX, NUM_CAND);
    end

    // Enable for the next cycle: the clock kind also needs the clock-output bit.
    always_comb begin
        case (drv_next.kind)
            DRV_STATIC, DRV_SIG: oe_next = 1'b1;
            DRV_CLK:             oe_next = clk_en_d;
            default:             oe_next = 1'b0;
        endcase
    end

    // Registered output enable, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_next;
    end

    // Select the data source from the stored code.
    always_comb begin
        case (drv_now.kind)
            DRV_STATIC: data_sel = drv_now.level;
            DRV_SIG:    data_sel = cand_in[drv_now.sig_idx[$clog2(NUM_CAND > 1 ? NUM_CAND : 2)-1:0]];
            DRV_CLK:    data_sel = rx_clk_in;
            default:    data_sel = 1'b0;
        endcase
    end

    // Gate data with the enable so an idle pin presents 0.
    always_comb begin
        pad_out = data_sel & oe_q;
        pad_oe  = oe_q;
    end

endmodule

// File: rtl/mfp_pin_sync.sv
// Two-flop synchronizer for the pin levels read back through the status
// address. Assumes pin levels may change at any time, relative to clk.
module mfp_pin_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1;

    // Two-stage capture of the pin levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end

endmodule

// File: rtl/mfp_port_mux.sv
// Top of the multi-function port mux for one channel: a register file, five
// pin slices (receive-side first, then transmit-side) and the readback
// synchronizer. Pin order in every vector: rx A, rx B, rx C, tx A, tx B.
module mfp_port_mux
    import mfp_pkg::*;
#(
    parameter int NUM_CAND = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [2:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [NUM_CAND-1:0] cand_in,
    input  logic                rx_clk_in,
    input  logic [4:0]          pin_in,
    output logic [4:0]          pin_out,
    output logic [4:0]          pin_oe
);

    logic [NUM_PINS-1:0][CODE_W-1:0] code_q;
    logic [NUM_PINS-1:0][CODE_W-1:0] code_d;
    logic                            clk_en_q;
    logic                            clk_en_d;
    logic [NUM_PINS-1:0]             pin_status;

    mfp_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .status_in (pin_status),
        .reg_rdata (reg_rdata),
        .code_q    (code_q),
        .code_d    (code_d),
        .clk_en_q  (clk_en_q),
        .clk_en_d  (clk_en_d)
    );

    genvar gp;
    generate
        for (gp = 0; gp < NUM_PINS; gp++) begin : g_pin
            mfp_pin_slice #(
                .IS_RX    (gp < NUM_RX),
                .NUM_CAND (NUM_CAND)
            ) u_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .code_q    (code_q[gp]),
                .code_d    (code_d[gp]),
                .clk_en_d  (clk_en_d),
                .cand_in   (cand_in),
                .rx_clk_in (rx_clk_in),
                .pad_out   (pin_out[gp]),
                .pad_oe    (pin_oe[gp])
            );
        end
    endgenerate

    mfp_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_status)
    );

endmodule

// File: rtl/mfp_port_mux_chk.sv
// Checker for mfp_port_mux, bound to every instance of it. It only watches
// top-level ports.
module mfp_port_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [4:0] pin_in,
    input logic [4:0] pin_out,
    input logic [4:0] pin_oe
);

    logic [1:0] since_rst;

    // Count cycles since reset release, saturating at 2.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == 5'd0));

    // R2
    input_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[3:0] == 4'd0) |=> !pin_oe[0]);

    // R3
    static_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd0 && reg_wdata[3:0] == 4'd2) |=> (pin_oe[0] && pin_out[0]));

    // R6
    undef_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 3'd2 && reg_wdata[3:0] >= 4'd11) |=> !pin_oe[4]);

    // R10
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out & ~pin_oe) == 5'd0));

    // R8
    status_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2 && reg_addr == 3'd4) |-> (reg_rdata == {3'b000, $past(pin_in, 2)}));

endmodule

bind mfp_port_mux mfp_port_mux_chk u_chk (.*);

// File: tb/mfp_port_mux_test.sv
// Directed bench for mfp_port_mux: one task per scenario, each checking itself.
module mfp_port_mux_test;

    localparam int NC = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_we = 1'b0;
    logic [2:0]    reg_addr = 3'd0;
    logic [7:0]    reg_wdata = 8'd0;
    logic [7:0]    reg_rdata;
    logic [NC-1:0] cand_in = '0;
    logic          rx_clk_in = 1'b0;
    logic [4:0]    pin_in = 5'd0;
    logic [4:0]    pin_out;
    logic [4:0]    pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mfp_port_mux #(.NUM_CAND(NC)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cand_in(cand_in),
        .rx_clk_in(rx_clk_in), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Write one register; returns at the falling edge after the sampling edge.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        @(negedge clk);
        chk("R1 oe after reset", pin_oe, 5'd0);
        chk("R10 out after reset", pin_out, 5'd0);
        rd(3'd0, d); chk("R1 addr0 reset", d, 8'h00);
        rd(3'd1, d); chk("R1 addr1 reset (clock code on rx C)", d, 8'h0F);
        rd(3'd2, d); chk("R1 addr2 reset", d, 8'h00);
        rd(3'd3, d); chk("R1 clock enable reset", d, 8'h00);
    endtask

    task automatic t_static();
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h21;
        #1;
        chk("R7 no change before edge", pin_oe[1:0], 2'b00);
        @(negedge clk);
        reg_we = 1'b0;
        chk("R7 R3 oe on write edge", pin_oe[1:0], 2'b11);
        chk("R3 low on rx A, high on rx B", pin_out[1:0], 2'b10);
        wr(3'd0, 8'h12);
        chk("R3 swapped levels", pin_out[1:0], 2'b01);
    endtask

    task automatic t_input();
        wr(3'd0, 8'h00);
        chk("R2 input code releases pins", pin_oe[1:0], 2'b00);
        chk("R10 idle pins read 0", pin_out[1:0], 2'b00);
    endtask

    task automatic t_cand();
        for (int i = 0; i < NC; i++) begin
            wr(3'd1, {4'(3 + i), 4'hF});
            cand_in = NC'(1) << i;
            #1;
            chk($sformatf("R4 tx A follows cand %0d high", i), {pin_oe[3], pin_out[3]}, 2'b11);
            cand_in = ~(NC'(1) << i);
            #1;
            chk($sformatf("R4 tx A follows cand %0d low", i), {pin_oe[3], pin_out[3]}, 2'b10);
        end
        cand_in = '0;
        wr(3'd1, 8'h0F);
    endtask

    task automatic t_clk();
        rx_clk_in = 1'b1;
        #1;
        chk("R5 clock pin undriven while disabled", {pin_oe[2], pin_out[2]}, 2'b00);
        wr(3'd3, 8'h01);
        chk("R5 clock pin driven high", {pin_oe[2], pin_out[2]}, 2'b11);
        rx_clk_in = 1'b0;
        #1;
        chk("R5 clock pin follows clock low", {pin_oe[2], pin_out[2]}, 2'b10);
        wr(3'd1, 8'h03);
        cand_in = 8'h01;
        #1;
        chk("R4 rx C switches to candidate 0", {pin_oe[2], pin_out[2]}, 2'b11);
        cand_in = '0;
        wr(3'd1, 8'h0F);
        wr(3'd3, 8'h00);
        chk("R5 clock pin released", pin_oe[2], 1'b0);
    endtask

    task automatic t_undef();
        for (int c = 11; c <= 15; c++) begin
            wr(3'd2, 8'h02);
            wr(3'd2, 8'(c));
            chk($sformatf("R6 tx B code %0d undefined", c), pin_oe[4], 1'b0);
        end
        wr(3'd0, 8'h0C);
        chk("R6 rx A code 12 undefined", pin_oe[0], 1'b0);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] d;
        @(negedge clk);
        pin_in = 5'b10110;
        @(negedge clk);
        rd(3'd4, d); chk("R8 not visible after one edge", d, 8'h00);
        @(negedge clk);
        rd(3'd4, d); chk("R8 visible after two edges", d, 8'h16);
    endtask

    task automatic t_regmap();
        logic [7:0] d;
        wr(3'd0, 8'hA5);
        wr(3'd2, 8'hFB);
        wr(3'd3, 8'hFE);
        wr(3'd4, 8'hFF);
        wr(3'd5, 8'hFF);
        rd(3'd0, d); chk("R9 addr0 readback", d, 8'hA5);
        rd(3'd2, d); chk("R9 addr2 upper bits read 0", d, 8'h0B);
        rd(3'd3, d); chk("R9 addr3 only bit 0", d, 8'h00);
        rd(3'd4, d); chk("R9 status write ignored", d, 8'h16);
        rd(3'd5, d); chk("R9 addr5 reads 0", d, 8'h00);
        rd(3'd1, d); chk("R9 addr1 untouched", d, 8'h0F);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'h00);
    endtask

    // Clock-enable write and pin level change land in the same cycle.
    task automatic t_coinc();
        logic [7:0] d;
        rx_clk_in = 1'b1;
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h01;
        pin_in = 5'b01001;
        @(negedge clk);
        reg_we = 1'b0;
        chk("R5 enable moves after one edge", pin_oe[2], 1'b1);
        rd(3'd4, d); chk("R8 old level after one edge", d, 8'h16);
        @(negedge clk);
        rd(3'd4, d); chk("R8 new level after two edges", d, 8'h09);
        wr(3'd3, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_static();
        t_input();
        t_cand();
        t_clk();
        t_undef();
        t_sync();
        t_regmap();
        t_coinc();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule